// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing core of a two-channel pulse-width modulator. It divides the module clock with a two-stage prescaler. The first stage multiplies by an even factor and the second by a power of two. On each divided tick the block advances a 16-bit counter against a shared period value. The counter can count upward, count downward, bounce between zero and the period, or stand still. The period register has a shadow copy. A new period can therefore wait for the next zero crossing, or it can take effect at once.

Software or a neighbouring controller programs the block through a simple one-cycle write port. Four word addresses select the control word, the period and the two compare values. The block presents the running count and the current counting direction. It also raises single-clock strobes when the count sits at zero, at the period, or at either compare value. Each compare strobe is split into an upward and a downward variant, so a downstream waveform stage can act differently on the rising and the falling slope.

Top module: `pwm_timebase`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears the count, the period (active and shadow) and both compares, and selects the control word freeze mode, shadow loading and a division of 1. After such an edge, count is 0, dir_down is 0 and no event output is high.
- R2: Control bits 9:7 hold a divider code h and bits 12:10 a code c. The counter may advance only once every D = 2^c * (h == 0 ? 1 : 2*h) clocks. A write to the control word restarts this D-clock phase from the edge that takes the write.
- R3: With mode bits 1:0 = 00 (up), each advance adds one. From a count at or above the active period P, the next advance goes to 0.
- R4: With mode 01 (down), each advance subtracts one. From a count of 0 or a count above P, the next advance loads P.
- R5: With mode 10 (up-down), the count rises until it reaches P and then falls until it reaches 0. At P the next advance goes to P-1, and at 0 it goes to 1 (with P = 0 the count stays at 0). dir_down is 1 while falling.
- R6: With mode 11 (freeze), the count and the up-down direction hold, and no event output is raised.
- R7: zero_evt (count 0) and prd_evt (count equal to P) are high for exactly the one clock that ends an advancing prescaler phase, while the count holds that value.
- R8: Compare A is at word address 2 and drives bit 0 of cmp_up/cmp_dn; compare B is at address 3 and drives bit 1. A compare bit is high under the same condition as R7, with the count equal to that compare value. The up bit is used when dir_down is 0 and the down bit when dir_down is 1. dir_down is 1 in down mode and on the falling slope of up-down mode, and 0 otherwise.
- R9: With control bit 3 = 0, a write to address 1 only sets the shadow period. The shadow value becomes the active P at the edge that ends a zero_evt clock.
- R10: With control bit 3 = 1, a write to address 1 sets the active P at the edge that takes the write.
- R11: Address 0 is the control word. Any write takes effect at the edge where wr_en is sampled high. An advance at that same edge still uses the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 2 | Word address: 0 control, 1 period, 2 compare A, 3 compare B |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | Current counting direction, 1 = falling |
| zero_evt | output | 1 | Count-at-zero strobe |
| prd_evt | output | 1 | Count-at-period strobe |
| cmp_up | output | 2 | Compare match strobes while rising, bit i = compare i |
| cmp_dn | output | 2 | Compare match strobes while falling, bit i = compare i |

## Verification
A write is visible from the rising edge that samples it. From that edge, the new compare or immediate period changes event decoding, and the new control word restarts the prescaler phase, so the first advance lands D edges later. The count changes at the edge that closes an advancing phase. The event strobes are decoded from registered state only, so they stand for the whole clock before that edge. The bench keeps a cycle model that it updates on the rising edge from the documented rules. It compares every output at the following falling edge, one edge after the stimulus driven on the previous falling edge. Directed phases for each mode, for both period loading styles and for the largest divider are mixed with seeded random writes that land at arbitrary moments against the counter.

// File: rtl/pwm_tb_pkg.sv
// Shared types and constants of the PWM time base.
// Assumes a 16-bit write bus so that every control field fits.
package pwm_tb_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_HOLD = 2'b11
    } cnt_mode_e;

    localparam int HS_W    = 3;
    localparam int CK_W    = 3;
    localparam int MODE_LO = 0;
    localparam int IMM_BIT = 3;
    localparam int HS_LO   = 7;
    localparam int CK_LO   = 10;
    // widest division: (2*(2^HS_W-1)) << (2^CK_W-1)
    localparam int DIV_W   = HS_W + 1 + (2**CK_W) - 1;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_PRD  = 1;
    localparam int ADDR_CMP0 = 2;

    typedef struct packed {
        cnt_mode_e        mode;
        logic             immed;
        logic [HS_W-1:0]  hs;
        logic [CK_W-1:0]  ck;
    } ctrl_t;

endpackage

// File: rtl/pwm_tb_regs.sv
// Register file: control word, period with shadow copy, compare values.
// Assumes one write per cycle; the shadow transfer strobe comes from the
// counter's zero step.
module pwm_tb_regs
    import pwm_tb_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NCMP = 2,
    parameter int AW   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CW-1:0]            wr_data,
    input  logic                     xfer,
    output ctrl_t                    ctrl_q,
    output logic                     ctrl_wr,
    output logic [CW-1:0]            prd_act,
    output logic [NCMP-1:0][CW-1:0]  cmp_q
);

    localparam ctrl_t CTRL_RST = '{mode: CM_HOLD, immed: 1'b0, hs: '0, ck: '0};

    logic [CW-1:0] prd_shd;
    logic          prd_wr;

    assign ctrl_wr = wr_en && (wr_addr == AW'(ADDR_CTRL));
    assign prd_wr  = wr_en && (wr_addr == AW'(ADDR_PRD));

    // Control word: decode the fields out of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl_q.mode  <= cnt_mode_e'(wr_data[MODE_LO +: 2]);
            ctrl_q.immed <= wr_data[IMM_BIT];
            ctrl_q.hs    <= wr_data[HS_LO +: HS_W];
            ctrl_q.ck    <= wr_data[CK_LO +: CK_W];
        end
    end

    // Shadow period: every period write lands here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_shd <= '0;
        end else if (prd_wr) begin
            prd_shd <= wr_data;
        end
    end

    // Active period: direct write in immediate mode, else zero-step transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_act <= '0;
        end else if (prd_wr && ctrl_q.immed) begin
            prd_act <= wr_data;
        end else if (xfer && !ctrl_q.immed) begin
            prd_act <= prd_shd;
        end
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        // Compare value i: plain write register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q[i] <= '0;
            end else if (wr_en && (wr_addr == AW'(ADDR_CMP0 + i))) begin
                cmp_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pwm_tb_prescale.sv
// Two-stage clock prescaler: even multiple (or 1) times a power of two.
// Produces a tick in the last clock of each division phase; a restart
// request clears the phase.
module pwm_tb_prescale
    import pwm_tb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [HS_W-1:0] hs,
    input  logic [CK_W-1:0] ck,
    output logic            tick
);

    logic [DIV_W-1:0] mult;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] pc_q;

    // Division factor minus one for the current codes.
    always_comb begin
        mult = (hs == '0) ? DIV_W'(1) : DIV_W'({hs, 1'b0});
        last = (mult << ck) - DIV_W'(1);
    end

    assign tick = (pc_q == last);

    // Phase counter: wraps after the last clock, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pwm_tb_counter.sv
// Time-base counter: up, down, up-down and freeze against the active period.
// Assumes the period may change at any time; out-of-range counts recover
// at the next advance.
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  cnt_mode_e     mode,
    input  logic [CW-1:0] prd,
    output logic [CW-1:0] cnt_q,
    output logic          step,
    output logic          dir_down
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic          ud_q;
    logic [CW-1:0] cnt_d;
    logic          ud_d;

    assign step     = tick && (mode != CM_HOLD);
    assign dir_down = (mode == CM_DOWN) || ((mode == CM_UPDN) && ud_q);

    // Next count and up-down direction for one advance.
    always_comb begin
        cnt_d = cnt_q;
        ud_d  = ud_q;
        if (step) begin
            unique case (mode)
                CM_UP:   cnt_d = (cnt_q >= prd) ? '0 : cnt_q + ONE;
                CM_DOWN: cnt_d = ((cnt_q == '0) || (cnt_q > prd)) ? prd : cnt_q - ONE;
                CM_UPDN: begin
                    if (!ud_q) begin
                        if (cnt_q >= prd) begin
                            ud_d  = 1'b1;
                            cnt_d = (prd == '0) ? '0 : prd - ONE;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end else begin
                        if (cnt_q == '0) begin
                            ud_d  = 1'b0;
                            cnt_d = (prd == '0) ? '0 : ONE;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end
    end

    // State registers of the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ud_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ud_q  <= ud_d;
        end
    end

endmodule

// File: rtl/pwm_tb_match.sv
// One compare channel: flags a match on an advancing step, split by direction.
// Purely combinational from registered state.
module pwm_tb_match #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic          step,
    input  logic          dir_down,
    output logic          hit_up,
    output logic          hit_dn
);

    logic hit;

    // Equality qualified by the advancing step.
    always_comb begin
        hit    = step && (cnt == cmp);
        hit_up = hit && !dir_down;
        hit_dn = hit && dir_down;
    end

endmodule

// File: rtl/pwm_timebase.sv
// Top of the PWM time base: registers, prescaler, counter and compare
// decoders. All outputs are decoded from registered state only.
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NCMP = 2,
    parameter int AW   = $clog2(NCMP + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [CW-1:0]   wr_data,
    output logic [CW-1:0]   count,
    output logic            dir_down,
    output logic            zero_evt,
    output logic            prd_evt,
    output logic [NCMP-1:0] cmp_up,
    output logic [NCMP-1:0] cmp_dn
);

    ctrl_t                   ctrl_s;
    logic                    ctrl_wr_s;
    logic [CW-1:0]           prd_act_s;
    logic [NCMP-1:0][CW-1:0] cmp_s;
    logic                    tick_s;
    logic                    step_s;
    logic [CW-1:0]           cnt_s;

    pwm_tb_regs #(.CW(CW), .NCMP(NCMP), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .xfer    (zero_evt),
        .ctrl_q  (ctrl_s),
        .ctrl_wr (ctrl_wr_s),
        .prd_act (prd_act_s),
        .cmp_q   (cmp_s)
    );

    pwm_tb_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr_s),
        .hs      (ctrl_s.hs),
        .ck      (ctrl_s.ck),
        .tick    (tick_s)
    );

    pwm_tb_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_s),
        .mode     (ctrl_s.mode),
        .prd      (prd_act_s),
        .cnt_q    (cnt_s),
        .step     (step_s),
        .dir_down (dir_down)
    );

    assign count    = cnt_s;
    assign zero_evt = step_s && (cnt_s == '0);
    assign prd_evt  = step_s && (cnt_s == prd_act_s);

    for (genvar i = 0; i < NCMP; i++) begin : g_match
        pwm_tb_match #(.CW(CW)) u_match (
            .cnt      (cnt_s),
            .cmp      (cmp_s[i]),
            .step     (step_s),
            .dir_down (dir_down),
            .hit_up   (cmp_up[i]),
            .hit_dn   (cmp_dn[i])
        );
    end

endmodule

// File: rtl/pwm_tb_chk.sv
// Property checker for the PWM time base, attached by bind.
module pwm_tb_chk
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [CW-1:0] wr_data,
    input logic [CW-1:0] count,
    input logic [CW-1:0] prd_act,
    input ctrl_t         ctrl,
    input logic          tick,
    input logic          zero_evt,
    input logic          prd_evt
);

    // R7
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> (count == '0));

    // R7
    prd_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prd_evt |-> (count == prd_act));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == CM_HOLD) |=> $stable(count));

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == CM_HOLD) |-> !(zero_evt || prd_evt));

    // R2
    notick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    // R3
    up_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl.mode == CM_UP && count < prd_act)
        |=> (count == $past(count) + CW'(1)));

    // R4
    down_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl.mode == CM_DOWN && count != '0 && count <= prd_act)
        |=> (count == $past(count) - CW'(1)));

    // R10
    immed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADDR_PRD) && ctrl.immed)
        |=> (prd_act == $past(wr_data)));

endmodule

bind pwm_timebase pwm_tb_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .count    (count),
    .prd_act  (prd_act_s),
    .ctrl     (ctrl_s),
    .tick     (tick_s),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt)
);

// File: tb/sim_pwm_timebase.sv
// Bench: cycle model updated on rising edges, outputs compared on falling.
module sim_pwm_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        dir_down, zero_evt, prd_evt;
    logic [1:0]  cmp_up, cmp_dn;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string phase_tag = "";

    // model state
    logic [15:0] m_ctrl, m_shd, m_act, m_cnt;
    logic [15:0] m_cmp [2];
    logic        m_ud;
    int          m_pc;

    always #4 clk = ~clk;

    pwm_timebase u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .dir_down(dir_down),
        .zero_evt(zero_evt), .prd_evt(prd_evt), .cmp_up(cmp_up), .cmp_dn(cmp_dn)
    );

    function automatic logic [15:0] mkctrl(int md, int imm, int hs, int ck);
        return 16'((ck << 10) | (hs << 7) | (imm << 3) | md);
    endfunction

    function automatic int div_of(logic [15:0] c);
        int h = int'(c[9:7]);
        return (1 << int'(c[12:10])) * ((h == 0) ? 1 : 2 * h);
    endfunction

    function automatic string mode_tag(logic [15:0] c);
        case (c[1:0])
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Cycle model built from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = mkctrl(3, 0, 0, 0);
            m_shd = 0; m_act = 0; m_cnt = 0; m_ud = 0; m_pc = 0;
            m_cmp[0] = 0; m_cmp[1] = 0;
        end else begin
            bit tk, st;
            logic [15:0] n_cnt;
            logic n_ud;
            tk = (m_pc == div_of(m_ctrl) - 1);
            st = tk && (m_ctrl[1:0] != 2'b11);
            n_cnt = m_cnt; n_ud = m_ud;
            if (st) begin
                case (m_ctrl[1:0])
                    2'b00: n_cnt = (m_cnt >= m_act) ? 16'd0 : m_cnt + 16'd1;
                    2'b01: n_cnt = (m_cnt == 0 || m_cnt > m_act) ? m_act : m_cnt - 16'd1;
                    2'b10: begin
                        if (!m_ud) begin
                            if (m_cnt >= m_act) begin
                                n_ud = 1; n_cnt = (m_act == 0) ? 16'd0 : m_act - 16'd1;
                            end else n_cnt = m_cnt + 16'd1;
                        end else begin
                            if (m_cnt == 0) begin
                                n_ud = 0; n_cnt = (m_act == 0) ? 16'd0 : 16'd1;
                            end else n_cnt = m_cnt - 16'd1;
                        end
                    end
                    default: ;
                endcase
            end
            if (st && m_cnt == 0 && !m_ctrl[3]) m_act = m_shd;
            m_pc = tk ? 0 : m_pc + 1;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_ctrl = wr_data; m_pc = 0; end
                    2'd1: begin
                        if (m_ctrl[3]) m_act = wr_data;
                        m_shd = wr_data;
                    end
                    2'd2: m_cmp[0] = wr_data;
                    default: m_cmp[1] = wr_data;
                endcase
            end
            m_cnt = n_cnt; m_ud = n_ud;
        end
    end

    // Lockstep comparison at the falling edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit st, e_dn;
            logic [1:0] e_up, e_cd;
            string ct;
            st = (m_pc == div_of(m_ctrl) - 1) && (m_ctrl[1:0] != 2'b11);
            e_dn = (m_ctrl[1:0] == 2'b01) || (m_ctrl[1:0] == 2'b10 && m_ud);
            for (int i = 0; i < 2; i++) begin
                e_up[i] = st && (m_cnt == m_cmp[i]) && !e_dn;
                e_cd[i] = st && (m_cnt == m_cmp[i]) && e_dn;
            end
            ct = (phase_tag != "") ? phase_tag : mode_tag(m_ctrl);
            chk(ct, "count", int'(count), int'(m_cnt));
            chk(mode_tag(m_ctrl), "dir_down", int'(dir_down), int'(e_dn));
            chk("R7", "zero_evt", int'(zero_evt), int'(st && m_cnt == 0));
            chk("R7", "prd_evt", int'(prd_evt), int'(st && m_cnt == m_act));
            chk("R8", "cmp_up", int'(cmp_up), int'(e_up));
            chk("R8", "cmp_dn", int'(cmp_dn), int'(e_cd));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=1 exp=0");
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1c5e);
        // R1: reset state
        idle(3);
        chk("R1", "reset count", int'(count), 0);
        chk("R1", "reset dir_down", int'(dir_down), 0);
        chk("R1", "reset events", int'({zero_evt, prd_evt, cmp_up, cmp_dn}), 0);
        idle(4);
        chk("R1", "held count", int'(count), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R10: immediate period load, up mode
        phase_tag = "R10";
        wr(0, mkctrl(0, 1, 0, 0));
        wr(1, 16'd9);
        wr(2, 16'd3);
        wr(3, 16'd9);
        idle(40);
        wr(1, 16'd5);
        idle(20);

        // R9: shadow period load, up mode
        phase_tag = "R9";
        wr(0, mkctrl(0, 0, 0, 0));
        wr(1, 16'd12);
        idle(30);
        wr(1, 16'd4);
        idle(30);

        // R2: prescaled advances, then the widest divider
        phase_tag = "R2";
        wr(0, mkctrl(0, 0, 3, 1));
        idle(120);
        wr(0, mkctrl(0, 0, 7, 7));
        idle(3700);

        // R4, R5, R6 directed modes
        phase_tag = "";
        wr(1, 16'd6);
        wr(0, mkctrl(1, 1, 1, 0));
        wr(1, 16'd6);
        idle(60);
        wr(0, mkctrl(2, 1, 0, 0));
        idle(60);
        wr(1, 16'd0);
        idle(10);
        wr(1, 16'd7);
        idle(20);
        wr(0, mkctrl(3, 1, 0, 0));
        idle(20);

        // R11: random writes colliding with advances
        phase_tag = "R11";
        for (int it = 0; it < 3000; it++) begin
            if ($urandom_range(7) == 0) begin
                int a = $urandom_range(3);
                case (a)
                    0: wr(0, mkctrl($urandom_range(3), $urandom_range(1),
                                    $urandom_range(3), $urandom_range(1)));
                    1: wr(1, ($urandom_range(15) == 0) ? 16'hFFFF : 16'($urandom_range(20)));
                    default: wr(2'(a), 16'($urandom_range(22)));
                endcase
            end else begin
                idle(1);
            end
        end
        idle(2);
        finish_run();
    end

endmodule